// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder

This block adds two unsigned operands and a carry-in and gives a true-polarity sum and carry-out. It is built from structural full-adder cells. Each cell's carry stage is a single inverting gate that yields the complement of the majority of its three inputs. No inverter restores the carry after any stage. The carry therefore travels down the chain as true and complemented values in turn.

The block relies on the full adder being self-dual: if all three inputs of a cell are complemented, both of its outputs are complemented. A cell at an odd bit position receives a complemented carry from the cell below it. Its two operand bits are inverted to match. Its inverting carry gate then turns the carry back to true polarity.

Both outputs of each cell's primitive stages are complemented relative to that cell's own inputs. As a result, odd cells produce a true sum bit and even cells need one sum inverter. That inverter sits off the carry path. The width is a parameter. When the width is odd, the last carry node is complemented and gets one final inverter, chosen by a generate branch.

Top module: `alt_rca`

## Requirements
- R1: For every operand pair and carry-in, `{co, sum}` equals the arithmetic value `a + b + ci` (WIDTH+1 bits).
- R2: Carry node k has two polarities. Node 0 is `ci`, and node k is the carry into bit k. Nodes with an even index carry the true carry. Nodes with an odd index carry its complement. No inverter lies between adjacent cells.
- R3: `co` is the true carry out of the top bit. At the default width of 4 it is taken straight from the last carry node with no inverter. At an odd width exactly one inverter is added.
- R4: Every sum bit `sum[i]` is in true polarity and equals `a[i] ^ b[i] ^ (carry into bit i)`. This holds for both even and odd cell positions.
- R5: Generate: when `a[i]` and `b[i]` are both 1, the carry into bit i+1 is 1 whatever the lower bits and `ci`. For i=3 this is visible on `co`.
- R6: Kill: when `a[i]` and `b[i]` are both 0, the carry into bit i+1 is 0. For i=3 this makes `co` 0.
- R7: Full propagate: `a ^ b` all ones with `ci`=1 gives `sum` all zeros and `co`=1. The carry crosses every cell in both polarities.
- R8: All-zero inputs give `sum`=0 and `co`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ci | input | 1 | Carry-in, true polarity |
| sum | output | WIDTH | Sum, true polarity |
| co | output | 1 | Carry-out, true polarity |

## Verification
The bound checker follows every input change. It checks the polarity of each internal carry node against a prefix carry computed from the operands, which covers the alternating true and complemented rail. It also checks the sum and carry-out against the arithmetic total and confirms that every sum bit is true. The bench cannot see the rail, so it shows polarity only through the ports. It walks every one of the 512 input combinations and runs directed generate, kill and full-propagate patterns in which the carry has to pass through both polarities.

// File: rtl/alt_rca_pkg.sv
package alt_rca_pkg;
   // Polarity of carry node k: node 0 is ci (true); each cell flips polarity.
   typedef enum logic {POL_TRUE = 1'b0, POL_COMP = 1'b1} rail_pol_e;

   function automatic rail_pol_e node_pol(input int k);
      return (k % 2 == 0) ? POL_TRUE : POL_COMP;
   endfunction

   function automatic bit cell_is_odd(input int i);
      return (i % 2) == 1;
   endfunction
endpackage

// File: rtl/cx_inv.sv
module cx_inv (
   input  logic x,
   output logic y
);
   assign y = ~x;
endmodule

// File: rtl/cx_maj_n.sv
// Single inverting carry gate: complement of majority.
module cx_maj_n (
   input  logic x,
   input  logic y,
   input  logic z,
   output logic cn
);
   logic both;
   logic any2;
   assign both = x & y;
   assign any2 = z & (x | y);
   assign cn   = ~(both | any2);
endmodule

// File: rtl/cx_sum_n.sv
// Inverting sum gate reusing the cell's complemented carry.
module cx_sum_n (
   input  logic x,
   input  logic y,
   input  logic z,
   input  logic cn,
   output logic sn
);
   logic all3;
   logic any1;
   assign all3 = x & y & z;
   assign any1 = cn & (x | y | z);
   assign sn   = ~(all3 | any1);
endmodule

// File: rtl/alt_fa_cell.sv
module alt_fa_cell #(
   parameter bit ODD = 1'b0
) (
   input  logic a,
   input  logic b,
   input  logic c_rail,
   output logic s,
   output logic c_next
);
   logic x_op;
   logic y_op;
   logic s_raw;

   generate
      if (ODD) begin : g_odd_in
         // carry arrives complemented; align the operand bits with it
         cx_inv u_inv_a (.x(a), .y(x_op));
         cx_inv u_inv_b (.x(b), .y(y_op));
      end else begin : g_even_in
         assign x_op = a;
         assign y_op = b;
      end
   endgenerate

   cx_maj_n u_carry (.x(x_op), .y(y_op), .z(c_rail), .cn(c_next));
   cx_sum_n u_sum   (.x(x_op), .y(y_op), .z(c_rail), .cn(c_next), .sn(s_raw));

   generate
      if (ODD) begin : g_odd_out
         // complemented inputs make the inverted sum gate true again
         assign s = s_raw;
      end else begin : g_even_out
         cx_inv u_inv_s (.x(s_raw), .y(s));
      end
   endgenerate
endmodule

// File: rtl/alt_rca.sv
module alt_rca #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co
);
   import alt_rca_pkg::*;

   localparam bit LAST_COMP = (node_pol(WIDTH) == POL_COMP);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("alt_rca: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH:0] carry_rail;
   assign carry_rail[0] = ci;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         alt_fa_cell #(.ODD(cell_is_odd(i))) u_cell (
            .a      (a[i]),
            .b      (b[i]),
            .c_rail (carry_rail[i]),
            .s      (sum[i]),
            .c_next (carry_rail[i+1])
         );
      end
   endgenerate

   generate
      if (LAST_COMP) begin : g_co_fix
         cx_inv u_inv_co (.x(carry_rail[WIDTH]), .y(co));
      end else begin : g_co_direct
         assign co = carry_rail[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/alt_rca_chk.sv
module alt_rca_chk #(
   parameter int WIDTH = 4
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             ci,
   input logic [WIDTH-1:0] sum,
   input logic             co,
   input logic [WIDTH:0]   rail
);
   logic [WIDTH:0] total;
   logic [WIDTH:0] true_c;

   always_comb begin
      total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};
      true_c[0] = ci;
      for (int k = 1; k <= WIDTH; k++) begin
         logic [WIDTH:0] m;
         logic [WIDTH:0] p;
         m = ({{WIDTH{1'b0}}, 1'b1} << k) - 1'b1;
         p = ({1'b0, a} & m) + ({1'b0, b} & m) + {{WIDTH{1'b0}}, ci};
         true_c[k] = p[k];
      end
   end

   always_comb begin
      // R1
      sum_total_chk: assert ({co, sum} == total);
      // R3
      co_true_chk: assert (co == true_c[WIDTH]);
      for (int k = 0; k <= WIDTH; k++) begin
         // R2
         rail_pol_chk: assert (rail[k] == ((k % 2 == 0) ? true_c[k] : ~true_c[k]));
      end
      for (int i = 0; i < WIDTH; i++) begin
         // R4
         sum_bit_chk: assert (sum[i] == (a[i] ^ b[i] ^ true_c[i]));
         // R5
         gen_chk: assert (!(a[i] && b[i]) || true_c[i+1]);
         // R6
         kill_chk: assert ((a[i] || b[i]) || !true_c[i+1]);
      end
   end
endmodule

bind alt_rca alt_rca_chk #(.WIDTH(WIDTH)) u_chk (
   .a(a), .b(b), .ci(ci), .sum(sum), .co(co), .rail(carry_rail)
);

// File: tb/alt_rca_tb.sv
module alt_rca_tb;
   localparam int W = 4;
   localparam int NV = 8;
   // entry: {a, b, ci, exp_sum, exp_co}
   localparam logic [13:0] VEC [NV] = '{
      {4'h0, 4'h0, 1'b0, 4'h0, 1'b0},   // R8
      {4'hA, 4'h5, 1'b1, 4'h0, 1'b1},   // R7 R2
      {4'hF, 4'h0, 1'b1, 4'h0, 1'b1},   // R7
      {4'h8, 4'h8, 1'b0, 4'h0, 1'b1},   // R5
      {4'h7, 4'h0, 1'b1, 4'h8, 1'b0},   // R6
      {4'h5, 4'h5, 1'b0, 4'hA, 1'b0},   // R4
      {4'hF, 4'hF, 1'b1, 4'hF, 1'b1},   // R1
      {4'h3, 4'h9, 1'b0, 4'hC, 1'b0}    // R1
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a, b, sum;
   logic ci, co;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   alt_rca #(.WIDTH(W)) u_dut (.a(a), .b(b), .ci(ci), .sum(sum), .co(co));

   task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
      @(negedge clk);
      a = va; b = vb; ci = vc;
      @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input logic [W:0] exp);
      n_chk++;
      if ({co, sum} !== exp) begin
         n_bad++;
         $display("FAIL %s a=%h b=%h ci=%b got=%h expected=%h", req, a, b, ci, {co, sum}, exp);
      end
   endtask

   initial begin
      a = '0; b = '0; ci = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R8: idle state with quiet inputs
      apply('0, '0, 1'b0);
      check("R8", '0);

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][13:10], VEC[v][9:6], VEC[v][5]);
         check("R1", {VEC[v][0], VEC[v][4:1]});
      end

      // R1 exhaustive against behavioural sum
      for (int n = 0; n < 512; n++) begin
         logic [8:0] s;
         s = n[8:0];
         apply(s[8:5], s[4:1], s[0]);
         check("R1", {1'b0, s[8:5]} + {1'b0, s[4:1]} + {4'b0, s[0]});
      end

      // R5: top-bit generate forces co regardless of lower bits and ci
      for (int l = 0; l < 8; l++) begin
         apply({1'b1, l[2:0]}, 4'b1000, 1'b0);
         n_chk++;
         if (co !== 1'b1) begin n_bad++; $display("FAIL R5 co=%b expected=1", co); end
      end
      // R6: top-bit kill clears co even with full lower propagate
      apply(4'b0111, 4'b0000, 1'b1);
      n_chk++;
      if (co !== 1'b0) begin n_bad++; $display("FAIL R6 co=%b expected=0", co); end
      // R2 R3: carry through both rail polarities reaches co true
      apply(4'b0101, 4'b1010, 1'b1);
      check("R3", 5'h10);
      // R4: sum bits true at even and odd positions
      apply(4'b1111, 4'b0000, 1'b0);
      check("R4", 5'h0F);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog got=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule